// File: doc/BRIEF.md
# Capability Memory Access Checker

This block sits beside the execute and memory stages of a processor pipeline and decides, for each data access or instruction fetch, whether the access is allowed by the capability that governs it. A capability is a tag bit, a permission vector, a base address and a length. The checker forms the virtual address, checks the tag, the right needed for the kind of access, and the byte-exact bounds. It also checks the alignment of capability-sized transfers. It returns the address, a pass flag and a cause code one clock cycle after the request.

The pipeline chooses which capability applies. Instruction fetches always use the program-counter capability, and the fetch address arrives as an absolute value. Legacy integer loads and stores set `use_dflt`. They are then checked against the default data capability, and the integer address is taken as the offset from its base. All other accesses are checked against the explicit capability supplied with the request, and the offset is a signed value.

Top module: `cap_access_check`

## Requirements
- R1: Results are registered. `out_valid` rises one cycle after a cycle with `in_valid` high, and `out_addr`, `out_ok` and `out_cause` hold their values while no request arrives. Synchronous reset clears `out_valid`, `out_ok`, `out_addr` and `out_cause`.
- R2: The capability is selected as follows:
  - kind 4 (fetch) uses the `pcc_*` capability and takes `offset` as the absolute address, whatever the value of `use_dflt`;
  - any other kind with `use_dflt`=1 uses the `dflt_*` capability;
  - otherwise the `cap_*` capability is used.
- R3: For non-fetch accesses, `out_addr` is the selected base plus the sign-extended `offset`, modulo 2^ADDR_W. It is driven even when the access fails.
- R4: A cleared tag on the selected capability gives cause 1 (tag). This check has the highest priority.
- R5: Required permission bits by kind: kind 0 (load data) needs bit 0, kind 1 (store data) needs bit 1, kind 2 (load capability) needs bit 3, kind 3 (store capability) needs bit 4, and kind 4 (fetch) needs bit 2. Kind codes 5 to 7 have no right. A missing right gives cause 2, which ranks below the tag check.
- R6: Bounds are checked at byte granularity with no wraparound. The access passes only if base ≤ address and address + size ≤ base + length, computed wide enough that base + length never overflows. Otherwise the cause is 3, which ranks below the permission check.
- R7: The `size` code selects the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes, and 4 to 7 are 32 bytes. Kinds 2 and 3 always use 32 bytes, whatever the code.
- R8: Kinds 2 and 3 need an address that is a multiple of 32. A misaligned access gives cause 4, which has the lowest priority.
- R9: `out_ok` is 1 exactly when `out_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| kind | input | 3 | Access kind code |
| size | input | 3 | Access size code |
| use_dflt | input | 1 | Legacy access through the default data capability |
| cap_tag | input | 1 | Explicit capability tag |
| cap_perm | input | PERM_W | Explicit capability permissions |
| cap_base | input | ADDR_W | Explicit capability base |
| cap_len | input | ADDR_W | Explicit capability length |
| dflt_tag | input | 1 | Default data capability tag |
| dflt_perm | input | PERM_W | Default data capability permissions |
| dflt_base | input | ADDR_W | Default data capability base |
| dflt_len | input | ADDR_W | Default data capability length |
| pcc_tag | input | 1 | Program-counter capability tag |
| pcc_perm | input | PERM_W | Program-counter capability permissions |
| pcc_base | input | ADDR_W | Program-counter capability base |
| pcc_len | input | ADDR_W | Program-counter capability length |
| offset | input | ADDR_W | Signed offset, or absolute fetch address |
| out_valid | output | 1 | Result present |
| out_addr | output | ADDR_W | Computed virtual address |
| out_ok | output | 1 | Access allowed |
| out_cause | output | 4 | Exception cause, 0 when allowed |

## Verification
Data accesses are tried with offsets strictly inside the region and at the last legal byte. They are also tried one byte past the end and with a negative offset, which separates an off-by-one limit from a correct one and signed from unsigned offsets. A region whose end lies exactly at 2^64 shows whether the limit sum wraps. Vectors that break two or three rules at once pin down the order of the causes. Legacy and fetch vectors carry a deliberately invalid explicit capability, so that choosing the wrong source shows up as a wrong cause or a wrong address.

// File: rtl/capchk_pkg.sv
package capchk_pkg;
  // permission bit positions inside the permission vector
  localparam int P_LD  = 0;
  localparam int P_ST  = 1;
  localparam int P_EX  = 2;
  localparam int P_LDC = 3;
  localparam int P_STC = 4;

  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_STORE  = 3'd1,
    K_CLOAD  = 3'd2,
    K_CSTORE = 3'd3,
    K_FETCH  = 3'd4
  } kind_e;

  typedef enum logic [3:0] {
    C_NONE  = 4'd0,
    C_TAG   = 4'd1,
    C_PERM  = 4'd2,
    C_LEN   = 4'd3,
    C_ALIGN = 4'd4
  } cause_e;
endpackage

// File: rtl/capchk_select.sv
module capchk_select
  import capchk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PERM_W = 8
) (
  input  logic [2:0]        kind,
  input  logic              use_dflt,
  input  logic              cap_tag,
  input  logic [PERM_W-1:0] cap_perm,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W-1:0] cap_len,
  input  logic              dflt_tag,
  input  logic [PERM_W-1:0] dflt_perm,
  input  logic [ADDR_W-1:0] dflt_base,
  input  logic [ADDR_W-1:0] dflt_len,
  input  logic              pcc_tag,
  input  logic [PERM_W-1:0] pcc_perm,
  input  logic [ADDR_W-1:0] pcc_base,
  input  logic [ADDR_W-1:0] pcc_len,
  output logic              s_tag,
  output logic [PERM_W-1:0] s_perm,
  output logic [ADDR_W-1:0] s_base,
  output logic [ADDR_W-1:0] s_len,
  output logic              s_abs
);
  always_comb begin
    s_abs = 1'b0;
    if (kind == K_FETCH) begin
      s_tag  = pcc_tag;
      s_perm = pcc_perm;
      s_base = pcc_base;
      s_len  = pcc_len;
      s_abs  = 1'b1;
    end else if (use_dflt) begin
      s_tag  = dflt_tag;
      s_perm = dflt_perm;
      s_base = dflt_base;
      s_len  = dflt_len;
    end else begin
      s_tag  = cap_tag;
      s_perm = cap_perm;
      s_base = cap_base;
      s_len  = cap_len;
    end
  end
endmodule

// File: rtl/capchk_perm.sv
module capchk_perm
  import capchk_pkg::*;
#(
  parameter int PERM_W = 8
) (
  input  logic [2:0]        kind,
  input  logic [PERM_W-1:0] perm,
  output logic              allowed
);
  always_comb begin
    case (kind)
      K_LOAD:   allowed = perm[P_LD];
      K_STORE:  allowed = perm[P_ST];
      K_CLOAD:  allowed = perm[P_LDC];
      K_CSTORE: allowed = perm[P_STC];
      K_FETCH:  allowed = perm[P_EX];
      default:  allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/capchk_bounds.sv
module capchk_bounds #(
  parameter int ADDR_W    = 64,
  parameter int CAP_BYTES = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] len,
  input  logic [ADDR_W-1:0] off,
  input  logic              abs_addr,
  input  logic [2:0]        size_code,
  input  logic              cap_sized,
  output logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic              aligned
);
  localparam int EW = ADDR_W + 2;
  localparam int AL = $clog2(CAP_BYTES);

  logic [EW-1:0] off_ext, base_ext, addr_ext, nbytes, limit_ext;

  always_comb begin
    if (cap_sized || size_code[2])
      nbytes = EW'(CAP_BYTES);
    else
      nbytes = EW'(1) << size_code[1:0];
  end

  always_comb begin
    base_ext  = {2'b00, base};
    off_ext   = abs_addr ? {2'b00, off} : {{2{off[ADDR_W-1]}}, off};
    addr_ext  = abs_addr ? off_ext : base_ext + off_ext;
    limit_ext = base_ext + {2'b00, len};
    in_range  = !addr_ext[EW-1] && (addr_ext >= base_ext) &&
                ((addr_ext + nbytes) <= limit_ext);
    aligned   = (addr_ext[AL-1:0] == '0);
    addr      = addr_ext[ADDR_W-1:0];
  end
endmodule

// File: rtl/cap_access_check.sv
module cap_access_check
  import capchk_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PERM_W    = 8,
  parameter int CAP_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        kind,
  input  logic [2:0]        size,
  input  logic              use_dflt,
  input  logic              cap_tag,
  input  logic [PERM_W-1:0] cap_perm,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W-1:0] cap_len,
  input  logic              dflt_tag,
  input  logic [PERM_W-1:0] dflt_perm,
  input  logic [ADDR_W-1:0] dflt_base,
  input  logic [ADDR_W-1:0] dflt_len,
  input  logic              pcc_tag,
  input  logic [PERM_W-1:0] pcc_perm,
  input  logic [ADDR_W-1:0] pcc_base,
  input  logic [ADDR_W-1:0] pcc_len,
  input  logic [ADDR_W-1:0] offset,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ok,
  output logic [3:0]        out_cause
);
  logic              s_tag, s_abs, perm_ok, in_range, aligned, cap_sized;
  logic [PERM_W-1:0] s_perm;
  logic [ADDR_W-1:0] s_base, s_len, addr_c;
  cause_e            cause_c;

  capchk_select #(.ADDR_W(ADDR_W), .PERM_W(PERM_W)) u_sel (
    .kind(kind), .use_dflt(use_dflt),
    .cap_tag(cap_tag), .cap_perm(cap_perm), .cap_base(cap_base), .cap_len(cap_len),
    .dflt_tag(dflt_tag), .dflt_perm(dflt_perm), .dflt_base(dflt_base), .dflt_len(dflt_len),
    .pcc_tag(pcc_tag), .pcc_perm(pcc_perm), .pcc_base(pcc_base), .pcc_len(pcc_len),
    .s_tag(s_tag), .s_perm(s_perm), .s_base(s_base), .s_len(s_len), .s_abs(s_abs)
  );

  capchk_perm #(.PERM_W(PERM_W)) u_perm (
    .kind(kind), .perm(s_perm), .allowed(perm_ok)
  );

  assign cap_sized = (kind == K_CLOAD) || (kind == K_CSTORE);

  capchk_bounds #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES)) u_bnd (
    .base(s_base), .len(s_len), .off(offset), .abs_addr(s_abs),
    .size_code(size), .cap_sized(cap_sized),
    .addr(addr_c), .in_range(in_range), .aligned(aligned)
  );

  // fixed priority: tag, right, bounds, alignment
  always_comb begin
    if (!s_tag)                     cause_c = C_TAG;
    else if (!perm_ok)              cause_c = C_PERM;
    else if (!in_range)             cause_c = C_LEN;
    else if (cap_sized && !aligned) cause_c = C_ALIGN;
    else                            cause_c = C_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_ok    <= 1'b0;
      out_cause <= 4'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= addr_c;
        out_ok    <= (cause_c == C_NONE);
        out_cause <= cause_c;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> out_valid);

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(out_addr) && $stable(out_cause) && !out_valid));

  a_r4_fetch_tag: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && kind == K_FETCH && !pcc_tag)) |-> (out_cause == C_TAG));

  a_r5_fetch_exec: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && kind == K_FETCH && pcc_tag && !pcc_perm[P_EX]))
      |-> (out_cause == C_PERM && !out_ok));

  // R8: an odd capability load through a valid capability with an even base can
  // only fail on bounds or alignment, never pass
  a_r8_odd_cap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && !use_dflt && kind == K_CLOAD && cap_tag &&
                          cap_perm[P_LDC] && offset[0] && !cap_base[0]))
      |-> (out_cause == C_LEN || out_cause == C_ALIGN));
endmodule

// File: tb/cap_access_check_test.sv
`timescale 1ns/1ps
module cap_access_check_test;
  localparam int AW = 64;
  localparam int PW = 8;

  typedef struct packed {
    logic [7:0]    req;
    logic [2:0]    kind;
    logic [2:0]    size;
    logic          legacy;
    logic          tag;
    logic [PW-1:0] perm;
    logic [AW-1:0] base;
    logic [AW-1:0] len;
    logic [AW-1:0] off;
    logic          eok;
    logic [3:0]    ecause;
    logic [AW-1:0] eaddr;
  } vec_t;

  localparam int NV = 19;
  localparam logic [AW-1:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam vec_t VECS [NV] = '{
    '{8'd3, 3'd0, 3'd2, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h10, 1'b1, 4'd0, 64'h1010},       // R3 plain load
    '{8'd5, 3'd0, 3'd2, 1'b0, 1'b1, 8'h1E, 64'h1000, 64'h40, 64'h10, 1'b0, 4'd2, 64'h1010},       // R5 no load right
    '{8'd4, 3'd0, 3'd2, 1'b0, 1'b0, 8'h00, 64'h1000, 64'h40, 64'h10, 1'b0, 4'd1, 64'h1010},       // R4 tag over perm
    '{8'd6, 3'd1, 3'd2, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h3C, 1'b1, 4'd0, 64'h103C},       // R6 last word
    '{8'd6, 3'd1, 3'd2, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h3D, 1'b0, 4'd3, 64'h103D},       // R6 one past
    '{8'd6, 3'd0, 3'd0, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, M1,     1'b0, 4'd3, 64'h0FFF},       // R6 negative
    '{8'd7, 3'd2, 3'd0, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h20, 1'b1, 4'd0, 64'h1020},       // R7 cap size forced
    '{8'd8, 3'd2, 3'd0, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h08, 1'b0, 4'd4, 64'h1008},       // R8 misaligned
    '{8'd5, 3'd3, 3'd4, 1'b0, 1'b1, 8'h08, 64'h1000, 64'h40, 64'h30, 1'b0, 4'd2, 64'h1030},       // R5 no store-cap
    '{8'd8, 3'd3, 3'd4, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h28, 1'b0, 4'd3, 64'h1028},       // R8 len over align
    '{8'd6, 3'd0, 3'd2, 1'b0, 1'b1, 8'h1F, 64'hFFFF_FFFF_FFFF_FFF8, 64'h8, 64'h4, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFC}, // R6 top
    '{8'd6, 3'd0, 3'd2, 1'b0, 1'b1, 8'h1F, 64'hFFFF_FFFF_FFFF_FFF8, 64'h8, 64'h5, 1'b0, 4'd3, 64'hFFFF_FFFF_FFFF_FFFD}, // R6 top+1
    '{8'd6, 3'd0, 3'd3, 1'b0, 1'b1, 8'h1F, 64'h10, M1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 4'd3, 64'h0}, // R6 signed
    '{8'd2, 3'd0, 3'd2, 1'b1, 1'b0, 8'h00, 64'h1000, 64'h40, 64'h2000, 1'b1, 4'd0, 64'h2000},     // R2 legacy
    '{8'd2, 3'd4, 3'd2, 1'b0, 1'b0, 8'h00, 64'h1000, 64'h40, 64'h10FC, 1'b1, 4'd0, 64'h10FC},     // R2 fetch
    '{8'd2, 3'd4, 3'd2, 1'b1, 1'b0, 8'h00, 64'h1000, 64'h40, 64'h0FFC, 1'b0, 4'd3, 64'h0FFC},     // R2 fetch below
    '{8'd5, 3'd5, 3'd2, 1'b0, 1'b1, 8'hFF, 64'h1000, 64'h40, 64'h10, 1'b0, 4'd2, 64'h1010},       // R5 bad kind
    '{8'd7, 3'd0, 3'd3, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h38, 1'b1, 4'd0, 64'h1038},       // R7 dword fits
    '{8'd7, 3'd0, 3'd3, 1'b0, 1'b1, 8'h1F, 64'h1000, 64'h40, 64'h39, 1'b0, 4'd3, 64'h1039}        // R7 dword over
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] kind = '0, size = '0;
  logic use_dflt = 1'b0;
  logic cap_tag = 1'b0, dflt_tag = 1'b1, pcc_tag = 1'b1;
  logic [PW-1:0] cap_perm = '0, dflt_perm = 8'h1F, pcc_perm = 8'h04;
  logic [AW-1:0] cap_base = '0, cap_len = '0;
  logic [AW-1:0] dflt_base = '0, dflt_len = M1;
  logic [AW-1:0] pcc_base = 64'h1000, pcc_len = 64'h100;
  logic [AW-1:0] offset = '0;
  logic out_valid, out_ok;
  logic [AW-1:0] out_addr;
  logic [3:0] out_cause;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cap_access_check uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .size(size),
    .use_dflt(use_dflt),
    .cap_tag(cap_tag), .cap_perm(cap_perm), .cap_base(cap_base), .cap_len(cap_len),
    .dflt_tag(dflt_tag), .dflt_perm(dflt_perm), .dflt_base(dflt_base), .dflt_len(dflt_len),
    .pcc_tag(pcc_tag), .pcc_perm(pcc_perm), .pcc_base(pcc_base), .pcc_len(pcc_len),
    .offset(offset), .out_valid(out_valid), .out_addr(out_addr), .out_ok(out_ok),
    .out_cause(out_cause)
  );

  task automatic check(input string what, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [2:0] s, input logic leg, input logic [AW-1:0] off);
    @(negedge clk);
    in_valid = 1'b1; kind = k; size = s; use_dflt = leg; offset = off;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired (R1): got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    check("R1 reset out_ok", 64'(out_ok), 64'd0);
    check("R1 reset out_cause", 64'(out_cause), 64'd0);
    check("R1 reset out_addr", out_addr, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      kind = VECS[i].kind; size = VECS[i].size; use_dflt = VECS[i].legacy;
      cap_tag = VECS[i].tag; cap_perm = VECS[i].perm;
      cap_base = VECS[i].base; cap_len = VECS[i].len; offset = VECS[i].off;
      @(negedge clk);
      check($sformatf("R1 vec %0d valid", i), 64'(out_valid), 64'd1);
      check($sformatf("R%0d vec %0d cause", VECS[i].req, i), 64'(out_cause), 64'(VECS[i].ecause));
      check($sformatf("R9 vec %0d ok", i), 64'(out_ok), 64'(VECS[i].eok));
      check($sformatf("R%0d vec %0d addr", VECS[i].req, i), out_addr, VECS[i].eaddr);
    end

    // R1 hold: idle cycle keeps the last result, valid drops
    in_valid = 1'b0; offset = 64'h5555;
    @(negedge clk);
    check("R1 idle valid", 64'(out_valid), 64'd0);
    check("R1 idle addr held", out_addr, 64'h1039);
    check("R1 idle cause held", 64'(out_cause), 64'd3);

    // R5 fetch without execute right
    pcc_perm = 8'h01;
    send(3'd4, 3'd2, 1'b0, 64'h1010);
    check("R5 fetch no exec cause", 64'(out_cause), 64'd2);
    // R4 fetch with cleared pcc tag
    pcc_perm = 8'h04; pcc_tag = 1'b0;
    send(3'd4, 3'd2, 1'b0, 64'h1010);
    check("R4 fetch tag cause", 64'(out_cause), 64'd1);
    pcc_tag = 1'b1;
    // R2 legacy access sees the default capability's cleared tag, not the explicit one
    dflt_tag = 1'b0; cap_tag = 1'b1; cap_perm = 8'h1F; cap_base = 64'h0; cap_len = M1;
    send(3'd1, 3'd2, 1'b1, 64'h2000);
    check("R2 legacy dflt tag", 64'(out_cause), 64'd1);
    dflt_tag = 1'b1; dflt_base = 64'h8000;
    send(3'd1, 3'd2, 1'b1, 64'h20);
    check("R2 legacy relative addr", out_addr, 64'h8020);
    check("R2 legacy ok", 64'(out_ok), 64'd1);

    // R1 reset clears a live result
    rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset cause", 64'(out_cause), 64'd0);
    check("R1 re-reset valid", 64'(out_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule